// File: doc/BRIEF.md
# Prioritized Dependence Count Gatherer

This block sits behind a bank of task-dependence graph slices. Each slice reports its results through three output FIFOs. The first carries the IDs of tasks it found ready outright. The second carries waiting-task notices, one for each time a finished producer releases a consumer held in that slice. The third carries partial dependence reports for tasks whose parameters were spread over several slices. The gatherer drains all of these FIFOs, one entry per cycle, and merges the partial reports into one verdict per task. Each task that becomes runnable is pushed to the downstream ready queue as a single-cycle release pulse.

Service order is fixed across the three kinds of FIFO: ready notices first, then waiting notices, then partial counts. Within one kind, the slices take turns. A task is held in flight until the handled-parameter counts in its partial reports add up to its total parameter count. At that point a task with no outstanding dependences is released. Any other task keeps its count in a per-task table, and each later waiting notice decrements that count. A waiting notice that reaches a task still in flight lowers its running sum, so an early notice is never lost.

Top module: `dep_gather`

## Requirements
- R1: While reset is held, no FIFO is popped. After reset, a release pulse appears only two cycles after some entry was popped.
- R2: In any cycle where at least one slice offers a ready notice, exactly one ready FIFO is popped and no other kind is popped.
- R3: When no ready notice is offered and at least one waiting notice is, exactly one waiting FIFO is popped and no count FIFO is popped.
- R4: Within one kind, the grant goes to the first offering slice at or after a per-kind pointer, searching upward with wrap-around. After each grant that pointer moves to the slice after the winner. All pointers start at slice 0.
- R5: At most one pop is raised across all FIFOs in any cycle.
- R6: A popped ready notice with ID x yields rel_valid with rel_id equal to x exactly two cycles after the pop cycle.
- R7: A count report carries three fields: the dependences seen by that slice (cnt_deps), the parameters that slice handled (cnt_nparm), and the task's total parameter count (cnt_total). For a task not in flight, the report starts a new running sum. For a task in flight, it adds to the running sum. The task stays in flight, with no release, while the handled parameters sum to less than the total.
- R8: The report that brings the handled sum to at least the total completes the task. If the running dependence sum is then zero or below, the task is released two cycles after that report's pop.
- R9: A completed task with a positive sum is held. Each waiting notice for it subtracts one. The notice that brings the count to zero releases the task two cycles after its pop, and the task returns to idle.
- R10: A waiting notice for a task still in flight subtracts one from its running sum without releasing it. The subtraction counts toward the R8 decision.
- R11: A waiting notice for an idle task changes nothing and produces no release.
- R12: A FIFO is popped only in a cycle where it presents valid data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rdy_valid | input | NG | Per slice: ready-notice FIFO not empty |
| rdy_id | input | NG*TW | Per slice: task ID at the head of the ready FIFO |
| rdy_pop | output | NG | Per slice: pop the ready FIFO |
| wait_valid | input | NG | Per slice: waiting-notice FIFO not empty |
| wait_id | input | NG*TW | Per slice: task ID at the head of the waiting FIFO |
| wait_pop | output | NG | Per slice: pop the waiting FIFO |
| cnt_valid | input | NG | Per slice: count FIFO not empty |
| cnt_id | input | NG*TW | Per slice: task ID of the head count report |
| cnt_deps | input | NG*CW | Per slice: dependences found by that slice |
| cnt_nparm | input | NG*PW | Per slice: parameters that slice handled |
| cnt_total | input | NG*PW | Per slice: total parameter count of the task |
| cnt_pop | output | NG | Per slice: pop the count FIFO |
| rel_valid | output | 1 | One-cycle push of a runnable task to the ready queue |
| rel_id | output | TW | ID of the released task |

## Verification
Pop decisions are combinational from the FIFO heads, so they are due in the same cycle the data is offered. The bench checks them shortly after driving the inputs at the falling edge. Every release is due exactly two cycles after the pop of the entry that caused it: one register captures the popped entry, and a second register holds the table's verdict. The reference model in the bench therefore keeps the popped entry for one step, resolves it on the next step, and compares the expected release at the falling edge after that. The rounds are directed: simultaneous offers of all three kinds, a split task with zero dependences, a held task drained by notices, an early notice for a task in flight, and a notice for an idle task. A long random mix follows them.

// File: rtl/dg_pkg.sv
package dg_pkg;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_RDY  = 2'd1,
    K_WAIT = 2'd2,
    K_CNT  = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FLIGHT = 2'd1,
    ST_HELD   = 2'd2
  } tstate_e;

  // Circular index helper for round-robin search.
  function automatic int dg_wrap(input int v, input int n);
    return v % n;
  endfunction

  // A task is complete once its handled parameters reach its total.
  function automatic bit dg_complete(input int seen, input int total);
    return seen >= total;
  endfunction

  // A dependence sum at or below zero means nothing is outstanding.
  function automatic bit dg_runnable(input int sum);
    return sum <= 0;
  endfunction

endpackage

// File: rtl/dg_rr_arb.sv
module dg_rr_arb #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gidx
);
  import dg_pkg::*;

  logic [IW-1:0] ptr_q;
  logic          hit;

  always_comb begin
    gnt  = '0;
    gidx = '0;
    hit  = 1'b0;
    for (int off = 0; off < N; off++) begin
      if (!hit && req[dg_wrap(int'(ptr_q) + off, N)]) begin
        gnt[dg_wrap(int'(ptr_q) + off, N)] = 1'b1;
        gidx = IW'(dg_wrap(int'(ptr_q) + off, N));
        hit  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (adv && hit) begin
      ptr_q <= IW'(dg_wrap(int'(gidx) + 1, N));
    end
  end

endmodule

// File: rtl/dg_gather_front.sv
module dg_gather_front #(
  parameter int NG = 4,
  parameter int TW = 4,
  parameter int CW = 4,
  parameter int PW = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NG-1:0]       rdy_valid,
  input  logic [NG*TW-1:0]    rdy_id,
  input  logic [NG-1:0]       wait_valid,
  input  logic [NG*TW-1:0]    wait_id,
  input  logic [NG-1:0]       cnt_valid,
  input  logic [NG*TW-1:0]    cnt_id,
  input  logic [NG*CW-1:0]    cnt_deps,
  input  logic [NG*PW-1:0]    cnt_nparm,
  input  logic [NG*PW-1:0]    cnt_total,
  output logic [NG-1:0]       rdy_pop,
  output logic [NG-1:0]       wait_pop,
  output logic [NG-1:0]       cnt_pop,
  output logic [TW-1:0]       sel_id,
  output logic                any_pop,
  output dg_pkg::kind_e       s_kind,
  output logic [TW-1:0]       s_id,
  output logic [CW-1:0]       s_deps,
  output logic [PW-1:0]       s_nparm,
  output logic [PW-1:0]       s_total
);
  import dg_pkg::*;

  localparam int NCLS = 3;
  localparam int GW   = (NG > 1) ? $clog2(NG) : 1;

  logic [NG-1:0] req_a [NCLS];
  logic [NG-1:0] gnt_a [NCLS];
  logic [GW-1:0] gix_a [NCLS];
  logic [NCLS-1:0] go;

  assign req_a[0] = rdy_valid;
  assign req_a[1] = wait_valid;
  assign req_a[2] = cnt_valid;

  // Fixed order across kinds: ready, then waiting, then counts.
  always_comb begin
    go    = '0;
    go[0] = !rst && (|req_a[0]);
    go[1] = !rst && !go[0] && (|req_a[1]);
    go[2] = !rst && !go[0] && !go[1] && (|req_a[2]);
  end

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    dg_rr_arb #(.N(NG), .IW(GW)) u_arb (
      .clk  (clk),
      .rst  (rst),
      .req  (req_a[c]),
      .adv  (go[c]),
      .gnt  (gnt_a[c]),
      .gidx (gix_a[c])
    );
  end

  assign rdy_pop  = go[0] ? gnt_a[0] : '0;
  assign wait_pop = go[1] ? gnt_a[1] : '0;
  assign cnt_pop  = go[2] ? gnt_a[2] : '0;
  assign any_pop  = |go;

  kind_e         sel_kind;
  logic [CW-1:0] sel_deps;
  logic [PW-1:0] sel_nparm;
  logic [PW-1:0] sel_total;

  always_comb begin
    sel_kind  = K_NONE;
    sel_id    = '0;
    sel_deps  = '0;
    sel_nparm = '0;
    sel_total = '0;
    if (go[0]) begin
      sel_kind = K_RDY;
      sel_id   = rdy_id[int'(gix_a[0])*TW +: TW];
    end else if (go[1]) begin
      sel_kind = K_WAIT;
      sel_id   = wait_id[int'(gix_a[1])*TW +: TW];
    end else if (go[2]) begin
      sel_kind  = K_CNT;
      sel_id    = cnt_id[int'(gix_a[2])*TW +: TW];
      sel_deps  = cnt_deps[int'(gix_a[2])*CW +: CW];
      sel_nparm = cnt_nparm[int'(gix_a[2])*PW +: PW];
      sel_total = cnt_total[int'(gix_a[2])*PW +: PW];
    end
  end

  // Capture stage: the popped entry is resolved in the next cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      s_kind  <= K_NONE;
      s_id    <= '0;
      s_deps  <= '0;
      s_nparm <= '0;
      s_total <= '0;
    end else begin
      s_kind  <= sel_kind;
      s_id    <= sel_id;
      s_deps  <= sel_deps;
      s_nparm <= sel_nparm;
      s_total <= sel_total;
    end
  end

endmodule

// File: rtl/dg_count_table.sv
module dg_count_table #(
  parameter int TW = 4,
  parameter int CW = 4,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  dg_pkg::kind_e s_kind,
  input  logic [TW-1:0] s_id,
  input  logic [CW-1:0] s_deps,
  input  logic [PW-1:0] s_nparm,
  input  logic [PW-1:0] s_total,
  output logic          rel_valid,
  output logic [TW-1:0] rel_id
);
  import dg_pkg::*;

  localparam int NT = 1 << TW;
  localparam int SW = CW + 3;
  localparam int QW = PW + 1;

  tstate_e               st_q   [NT];
  logic signed [SW-1:0]  acc_q  [NT];
  logic [QW-1:0]         seen_q [NT];

  tstate_e               cur_st, nst;
  logic signed [SW-1:0]  cur_acc, base_acc, nacc;
  logic [QW-1:0]         cur_seen, base_seen, nseen;
  logic                  wr, rel;

  assign cur_st   = st_q[s_id];
  assign cur_acc  = acc_q[s_id];
  assign cur_seen = seen_q[s_id];

  always_comb begin
    nst       = cur_st;
    nacc      = cur_acc;
    nseen     = cur_seen;
    base_acc  = '0;
    base_seen = '0;
    wr        = 1'b0;
    rel       = 1'b0;
    unique case (s_kind)
      K_RDY: rel = 1'b1;
      K_WAIT: begin
        if (cur_st == ST_HELD) begin
          wr   = 1'b1;
          nacc = cur_acc - SW'(1);
          if (dg_runnable(int'(nacc))) begin
            rel = 1'b1;
            nst = ST_IDLE;
          end
        end else if (cur_st == ST_FLIGHT) begin
          wr   = 1'b1;
          nacc = cur_acc - SW'(1);
        end
      end
      K_CNT: begin
        wr = 1'b1;
        if (cur_st == ST_FLIGHT) begin
          base_acc  = cur_acc;
          base_seen = cur_seen;
        end
        nacc  = base_acc + $signed({{(SW-CW){1'b0}}, s_deps});
        nseen = base_seen + QW'(s_nparm);
        if (dg_complete(int'(nseen), int'(s_total))) begin
          if (dg_runnable(int'(nacc))) begin
            rel = 1'b1;
            nst = ST_IDLE;
          end else begin
            nst = ST_HELD;
          end
        end else begin
          nst = ST_FLIGHT;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NT; i++) begin
        st_q[i]   <= ST_IDLE;
        acc_q[i]  <= '0;
        seen_q[i] <= '0;
      end
      rel_valid <= 1'b0;
      rel_id    <= '0;
    end else begin
      rel_valid <= rel;
      rel_id    <= s_id;
      if (wr) begin
        st_q[s_id]   <= nst;
        acc_q[s_id]  <= nacc;
        seen_q[s_id] <= nseen;
      end
    end
  end

endmodule

// File: rtl/dep_gather.sv
module dep_gather #(
  parameter int NG = 4,
  parameter int TW = 4,
  parameter int CW = 4,
  parameter int PW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NG-1:0]    rdy_valid,
  input  logic [NG*TW-1:0] rdy_id,
  output logic [NG-1:0]    rdy_pop,
  input  logic [NG-1:0]    wait_valid,
  input  logic [NG*TW-1:0] wait_id,
  output logic [NG-1:0]    wait_pop,
  input  logic [NG-1:0]    cnt_valid,
  input  logic [NG*TW-1:0] cnt_id,
  input  logic [NG*CW-1:0] cnt_deps,
  input  logic [NG*PW-1:0] cnt_nparm,
  input  logic [NG*PW-1:0] cnt_total,
  output logic [NG-1:0]    cnt_pop,
  output logic             rel_valid,
  output logic [TW-1:0]    rel_id
);
  import dg_pkg::*;

  // Named internal events, observed by the bound checker.
  logic [TW-1:0] sel_id;
  logic          any_pop;

  kind_e         s_kind;
  logic [TW-1:0] s_id;
  logic [CW-1:0] s_deps;
  logic [PW-1:0] s_nparm;
  logic [PW-1:0] s_total;

  dg_gather_front #(.NG(NG), .TW(TW), .CW(CW), .PW(PW)) u_front (
    .clk        (clk),
    .rst        (rst),
    .rdy_valid  (rdy_valid),
    .rdy_id     (rdy_id),
    .wait_valid (wait_valid),
    .wait_id    (wait_id),
    .cnt_valid  (cnt_valid),
    .cnt_id     (cnt_id),
    .cnt_deps   (cnt_deps),
    .cnt_nparm  (cnt_nparm),
    .cnt_total  (cnt_total),
    .rdy_pop    (rdy_pop),
    .wait_pop   (wait_pop),
    .cnt_pop    (cnt_pop),
    .sel_id     (sel_id),
    .any_pop    (any_pop),
    .s_kind     (s_kind),
    .s_id       (s_id),
    .s_deps     (s_deps),
    .s_nparm    (s_nparm),
    .s_total    (s_total)
  );

  dg_count_table #(.TW(TW), .CW(CW), .PW(PW)) u_table (
    .clk       (clk),
    .rst       (rst),
    .s_kind    (s_kind),
    .s_id      (s_id),
    .s_deps    (s_deps),
    .s_nparm   (s_nparm),
    .s_total   (s_total),
    .rel_valid (rel_valid),
    .rel_id    (rel_id)
  );

endmodule

// File: rtl/dep_gather_chk.sv
module dep_gather_chk #(
  parameter int NG = 4,
  parameter int TW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [NG-1:0] rdy_valid,
  input logic [NG-1:0] wait_valid,
  input logic [NG-1:0] cnt_valid,
  input logic [NG-1:0] rdy_pop,
  input logic [NG-1:0] wait_pop,
  input logic [NG-1:0] cnt_pop,
  input logic [TW-1:0] sel_id,
  input logic          any_pop,
  input logic          rel_valid,
  input logic [TW-1:0] rel_id
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |-> ({rdy_pop, wait_pop, cnt_pop} == '0));  // R1

  AST_REL_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rel_valid |-> $past(any_pop, 2));  // R1

  AST_READY_FIRST: assert property (@(posedge clk) disable iff (rst)
    (|rdy_valid) |-> ((|rdy_pop) && wait_pop == '0 && cnt_pop == '0));  // R2

  AST_WAIT_OVER_COUNT: assert property (@(posedge clk) disable iff (rst)
    (!(|rdy_valid) && (|wait_valid)) |-> ((|wait_pop) && cnt_pop == '0));  // R3

  AST_ONE_POP: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rdy_pop, wait_pop, cnt_pop}));  // R5

  AST_READY_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (|rdy_pop) |=> ##1 (rel_valid && rel_id == $past(sel_id, 2)));  // R6

  AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
    ((rdy_pop & ~rdy_valid) | (wait_pop & ~wait_valid) | (cnt_pop & ~cnt_valid)) == '0);  // R12

endmodule

bind dep_gather dep_gather_chk #(.NG(NG), .TW(TW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rdy_valid  (rdy_valid),
  .wait_valid (wait_valid),
  .cnt_valid  (cnt_valid),
  .rdy_pop    (rdy_pop),
  .wait_pop   (wait_pop),
  .cnt_pop    (cnt_pop),
  .sel_id     (sel_id),
  .any_pop    (any_pop),
  .rel_valid  (rel_valid),
  .rel_id     (rel_id)
);

// File: tb/tb_dep_gather.sv
module tb_dep_gather;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 4;
  localparam int TW = 4;
  localparam int CW = 4;
  localparam int PW = 3;
  localparam int NT = 1 << TW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NG-1:0]    rdy_valid = '0, wait_valid = '0, cnt_valid = '0;
  logic [NG*TW-1:0] rdy_id = '0, wait_id = '0, cnt_id = '0;
  logic [NG*CW-1:0] cnt_deps = '0;
  logic [NG*PW-1:0] cnt_nparm = '0, cnt_total = '0;
  logic [NG-1:0]    rdy_pop, wait_pop, cnt_pop;
  logic             rel_valid;
  logic [TW-1:0]    rel_id;

  always #(CLK_PERIOD/2) clk = ~clk;

  dep_gather #(.NG(NG), .TW(TW), .CW(CW), .PW(PW)) dut (
    .clk(clk), .rst(rst),
    .rdy_valid(rdy_valid), .rdy_id(rdy_id), .rdy_pop(rdy_pop),
    .wait_valid(wait_valid), .wait_id(wait_id), .wait_pop(wait_pop),
    .cnt_valid(cnt_valid), .cnt_id(cnt_id), .cnt_deps(cnt_deps),
    .cnt_nparm(cnt_nparm), .cnt_total(cnt_total), .cnt_pop(cnt_pop),
    .rel_valid(rel_valid), .rel_id(rel_id)
  );

  typedef struct { int id; int deps; int np; int tot; } crep_t;

  int    rq [NG][$];
  int    wq [NG][$];
  crep_t cq [NG][$];

  // Reference state: 0 idle, 1 in flight, 2 held.
  int mst [NT];
  int macc [NT];
  int mseen [NT];
  int mptr [3];

  int    s1_kind = 0;
  crep_t s1;
  bit    exp_rv = 1'b0;
  int    exp_rid = 0;
  string exp_tag = "R1";

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic bit has(input int c, input int g);
    if (c == 0) return rq[g].size() != 0;
    if (c == 1) return wq[g].size() != 0;
    return cq[g].size() != 0;
  endfunction

  // Resolve the entry popped one step earlier.
  task automatic resolve(output bit rv, output int rid, output string tag);
    int base, bseen;
    rv = 1'b0; rid = s1.id; tag = "R1";
    if (s1_kind == 1) begin
      rv = 1'b1; tag = "R6";
    end else if (s1_kind == 2) begin
      if (mst[s1.id] == 2) begin
        macc[s1.id]--;
        tag = "R9";
        if (macc[s1.id] <= 0) begin rv = 1'b1; mst[s1.id] = 0; end
      end else if (mst[s1.id] == 1) begin
        macc[s1.id]--; tag = "R10";
      end else begin
        tag = "R11";
      end
    end else if (s1_kind == 3) begin
      base  = (mst[s1.id] == 1) ? macc[s1.id] : 0;
      bseen = (mst[s1.id] == 1) ? mseen[s1.id] : 0;
      macc[s1.id]  = base + s1.deps;
      mseen[s1.id] = bseen + s1.np;
      if (mseen[s1.id] >= s1.tot) begin
        tag = "R8";
        if (macc[s1.id] <= 0) begin rv = 1'b1; mst[s1.id] = 0; end
        else begin mst[s1.id] = 2; tag = "R9"; end
      end else begin
        mst[s1.id] = 1; tag = "R7";
      end
    end
  endtask

  task automatic step();
    bit nrv; int nrid; string ntag;
    int cls, gw;
    logic [3*NG-1:0] exp_pop, act_pop;
    @(negedge clk);
    chk(rel_valid === exp_rv && (!exp_rv || rel_id === exp_rid[TW-1:0]), exp_tag,
        {rel_valid, rel_id}, {exp_rv, exp_rid[TW-1:0]});
    nrv = 1'b0; nrid = 0; ntag = "R1";
    if (!rst) resolve(nrv, nrid, ntag);
    for (int g = 0; g < NG; g++) begin
      rdy_valid[g]  = rq[g].size() != 0;
      rdy_id[g*TW +: TW] = rdy_valid[g] ? TW'(rq[g][0]) : '0;
      wait_valid[g] = wq[g].size() != 0;
      wait_id[g*TW +: TW] = wait_valid[g] ? TW'(wq[g][0]) : '0;
      cnt_valid[g]  = cq[g].size() != 0;
      cnt_id[g*TW +: TW]    = cnt_valid[g] ? TW'(cq[g][0].id) : '0;
      cnt_deps[g*CW +: CW]  = cnt_valid[g] ? CW'(cq[g][0].deps) : '0;
      cnt_nparm[g*PW +: PW] = cnt_valid[g] ? PW'(cq[g][0].np) : '0;
      cnt_total[g*PW +: PW] = cnt_valid[g] ? PW'(cq[g][0].tot) : '0;
    end
    #1;
    cls = -1; gw = -1; exp_pop = '0;
    if (!rst) begin
      for (int c = 0; c < 3; c++)
        for (int g = 0; g < NG; g++)
          if (cls < 0 && has(c, g)) cls = c;
      if (cls >= 0) begin
        for (int k = 0; k < NG; k++)
          if (gw < 0 && has(cls, (mptr[cls] + k) % NG)) gw = (mptr[cls] + k) % NG;
        exp_pop[cls*NG + gw] = 1'b1;
      end
    end
    act_pop = {cnt_pop, wait_pop, rdy_pop};
    chk(act_pop === exp_pop,
        rst ? "R1" : (cls == 0) ? "R2" : (cls == 1) ? "R3" : (cls == 2) ? "R4" : "R12",
        int'(act_pop), int'(exp_pop));
    chk($countones(act_pop) <= 1, "R5", $countones(act_pop), 1);
    s1_kind = 0;
    if (cls >= 0) begin
      mptr[cls] = (gw + 1) % NG;
      s1_kind = cls + 1;
      if (cls == 0) begin s1.id = rq[gw].pop_front(); s1.deps = 0; s1.np = 0; s1.tot = 0; end
      else if (cls == 1) begin s1.id = wq[gw].pop_front(); s1.deps = 0; s1.np = 0; s1.tot = 0; end
      else s1 = cq[gw].pop_front();
    end
    exp_rv = nrv; exp_rid = nrid; exp_tag = ntag;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  function automatic crep_t mk(input int id, input int deps, input int np, input int tot);
    crep_t r;
    r.id = id; r.deps = deps; r.np = np; r.tot = tot;
    return r;
  endfunction

  initial begin
    for (int i = 0; i < NT; i++) begin mst[i] = 0; macc[i] = 0; mseen[i] = 0; end
    for (int c = 0; c < 3; c++) mptr[c] = 0;
    // R1: quiet during reset
    run(4);
    rst = 1'b0;
    run(2);
    // R2 R3 R4: all kinds offered together; ready first, then waiting, then counts
    for (int g = 0; g < NG; g++) begin
      rq[g].push_back(g + 1);
      wq[g].push_back(12);
      cq[g].push_back(mk(13 + (g % 2), 0, 1, 2));
    end
    rq[2].push_back(6);
    run(16);
    // R7 R8: split task with zero dependences
    cq[0].push_back(mk(3, 0, 1, 3));
    cq[1].push_back(mk(3, 0, 2, 3));
    run(6);
    // R9: held task released by three notices
    cq[2].push_back(mk(5, 2, 1, 2));
    cq[3].push_back(mk(5, 1, 1, 2));
    run(6);
    wq[1].push_back(5); run(4);
    wq[3].push_back(5); run(4);
    wq[0].push_back(5); run(5);
    // R10: early notice lowers a sum in flight
    cq[0].push_back(mk(7, 1, 1, 2)); run(4);
    wq[2].push_back(7); run(4);
    cq[1].push_back(mk(7, 0, 1, 2)); run(5);
    // R11: notice for an idle task
    wq[3].push_back(9); run(5);
    // Mixed random traffic
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 3) == 0) rq[$urandom_range(0, NG-1)].push_back($urandom_range(0, NT-1));
      if ($urandom_range(0, 4) == 0) wq[$urandom_range(0, NG-1)].push_back($urandom_range(0, NT-1));
      if ($urandom_range(0, 1) == 0)
        cq[$urandom_range(0, NG-1)].push_back(mk($urandom_range(0, NT-1), $urandom_range(0, 2),
                                                 $urandom_range(1, 3), $urandom_range(1, 7)));
      step();
    end
    run(400);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule